// File: doc/BRIEF.md
# Solid-Colour Triangle Rasterizer with Per-Row Edge Table

This block fills a triangle with one flat colour. A caller presents three vertices with unsigned integer coordinates and a colour, then pulses `start`. The block produces the covered pixels one at a time on a valid/ready pixel stream. A downstream framebuffer writer consumes that stream.

Work runs in two phases. In the first phase, three edge tracers run side by side. Each one walks one edge of the triangle and records, for every screen row the edge crosses, an x coordinate in its own slot of a per-row table. The table row index is the screen row minus the smallest vertex y. In the second phase, a span stage visits the table rows from the top row to the bottom row. For each row it takes the smallest and largest recorded x and emits every pixel between them, from left to right. A one-cycle `done` pulse closes the triangle.

Top module: `tri_span_raster`

## Requirements
- R1: After reset, `busy`, `done` and `pix_valid` are all low.
- R2: `start` is taken only while the block is idle. `busy` is high in the cycle after the accepting edge. A `start` seen while busy has no effect on the pixels that the current triangle produces.
- R3: Pixel rows run from y_min = min(v1_y, v2_y, v3_y) down to y_max = max of the three vertex y values. Each row is visited once, in increasing y. No row outside that range is emitted. The height y_max − y_min must be below `DEPTH`.
- R4: Slot 0 of each row is written by the edge v1→v2, slot 1 by the edge v2→v3, and slot 2 by the edge v3→v1. Each edge is traced from its first vertex with the integer line stepper: dx=|Δx|, ndy=−|Δy|, err=dx+ndy. At each step the current pixel is plotted and the stepper stops at the end vertex. Otherwise, with e2=2·err: if e2≥ndy then err+=ndy and x steps toward the end; if e2≤dx then err+=dx and y steps toward the end. A slot keeps the x of the last pixel that its edge plotted in that row.
- R5: Each row's run covers every x from the smallest to the largest x held in that row's valid slots. It is emitted with x rising by one per pixel, whatever the winding order of the vertices.
- R6: Every emitted pixel carries the `fill_col` value captured at the accepting `start`.
- R7: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_x`, `pix_y` and `pix_col` hold their values. A pixel counts as transferred on a clock edge where both signals are high.
- R8: `done` is high for exactly one cycle. That cycle directly follows the edge that transferred the last pixel. `busy` is low in the next cycle.
- R9: All slot valid flags are cleared when a triangle starts. Entries left by an earlier triangle never widen a later run.
- R10: With `pix_ready` held high, the time from the first transferred pixel to `done` is at most 3 cycles per pixel.
- R11: Degenerate triangles are drawn as well. Three equal vertices give exactly one pixel. Three vertices on one row give a single run from the smallest to the largest vertex x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a triangle (taken when idle) |
| v1_x | input | CRD_W | Vertex 1 x |
| v1_y | input | CRD_W | Vertex 1 y |
| v2_x | input | CRD_W | Vertex 2 x |
| v2_y | input | CRD_W | Vertex 2 y |
| v3_x | input | CRD_W | Vertex 3 x |
| v3_y | input | CRD_W | Vertex 3 y |
| fill_col | input | COL_W | Fill colour |
| busy | output | 1 | Triangle in progress |
| done | output | 1 | One-cycle completion pulse |
| pix_valid | output | 1 | Pixel present |
| pix_ready | input | 1 | Consumer accepts pixel |
| pix_x | output | CRD_W | Pixel x |
| pix_y | output | CRD_W | Pixel y |
| pix_col | output | COL_W | Pixel colour |

## Verification
The bench compares each stream against its own model of the line stepper and the per-row min/max. It targets shallow edges that hit one row several times, where keeping the wrong x of the row shifts the run ends. It also uses clockwise and anticlockwise windings, where a missing swap would give empty or reversed runs. A tall triangle followed by a short one that shares its rows exposes a table that is not cleared: stale slots would stretch the later runs. Ready patterns that stall, a stray `start` in mid-draw, a single point and a flat row show up lost or repeated pixels, a restart, a missing run and a late or long `done`.

// File: rtl/tri_raster_pkg.sv
package tri_raster_pkg;
    localparam int NSLOT = 3;

    typedef enum logic [2:0] {
        SP_IDLE,
        SP_WALK,
        SP_SCAN,
        SP_EMIT,
        SP_DONE
    } span_st_e;

    typedef enum logic [1:0] {
        EW_IDLE,
        EW_RUN,
        EW_FIN
    } walk_st_e;
endpackage

// File: rtl/tri_edge_walker.sv
module tri_edge_walker
    import tri_raster_pkg::*;
#(
    parameter int CRD_W = 8,
    parameter int RW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CRD_W-1:0] ax,
    input  logic [CRD_W-1:0] ay,
    input  logic [CRD_W-1:0] bx,
    input  logic [CRD_W-1:0] by,
    input  logic [CRD_W-1:0] y_base,
    output logic             wr_en,
    output logic [RW-1:0]    wr_row,
    output logic [CRD_W-1:0] wr_x,
    output logic             finished
);
    localparam int EW = CRD_W + 4;

    typedef struct packed {
        walk_st_e          st;
        logic [CRD_W-1:0]  x;
        logic [CRD_W-1:0]  y;
        logic [CRD_W-1:0]  ex;
        logic [CRD_W-1:0]  ey;
        logic [CRD_W-1:0]  ybase;
        logic signed [EW-1:0] err;
        logic signed [EW-1:0] dx;
        logic signed [EW-1:0] ndy;
        logic              xneg;
        logic              yneg;
    } wstate_t;

    wstate_t q, d;
    logic [CRD_W-1:0]     adx, ady;
    logic signed [EW-1:0] e2, err_n;

    function automatic logic signed [EW-1:0] widen(input logic [CRD_W-1:0] v);
        return $signed({{(EW-CRD_W){1'b0}}, v});
    endfunction

    always_comb begin
        d     = q;
        adx   = (ax >= bx) ? ax - bx : bx - ax;
        ady   = (ay >= by) ? ay - by : by - ay;
        e2    = q.err <<< 1;
        err_n = q.err;
        case (q.st)
            EW_IDLE, EW_FIN: begin
                if (go) begin
                    d.st    = EW_RUN;
                    d.x     = ax;
                    d.y     = ay;
                    d.ex    = bx;
                    d.ey    = by;
                    d.ybase = y_base;
                    d.dx    = widen(adx);
                    d.ndy   = -widen(ady);
                    d.err   = widen(adx) - widen(ady);
                    d.xneg  = (bx < ax);
                    d.yneg  = (by < ay);
                end
            end
            EW_RUN: begin
                if (q.x == q.ex && q.y == q.ey) begin
                    d.st = EW_FIN;
                end else begin
                    if (e2 >= q.ndy) begin
                        err_n = err_n + q.ndy;
                        d.x   = q.xneg ? q.x - 1'b1 : q.x + 1'b1;
                    end
                    if (e2 <= q.dx) begin
                        err_n = err_n + q.dx;
                        d.y   = q.yneg ? q.y - 1'b1 : q.y + 1'b1;
                    end
                    d.err = err_n;
                end
            end
            default: d.st = EW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_en    = (q.st == EW_RUN);
    assign wr_x     = q.x;
    assign wr_row   = RW'(q.y - q.ybase);
    assign finished = (q.st == EW_FIN);
endmodule

// File: rtl/tri_span_table.sv
module tri_span_table
    import tri_raster_pkg::*;
#(
    parameter int CRD_W = 8,
    parameter int DEPTH = 32,
    parameter int RW    = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic [NSLOT-1:0]             wr_en,
    input  logic [NSLOT-1:0][RW-1:0]     wr_row,
    input  logic [NSLOT-1:0][CRD_W-1:0]  wr_x,
    input  logic [RW-1:0]                rd_row,
    output logic [NSLOT-1:0]             rd_v,
    output logic [NSLOT-1:0][CRD_W-1:0]  rd_x
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [DEPTH-1:0] v_q, v_d;
        logic [CRD_W-1:0] x_q [DEPTH];
        logic [CRD_W-1:0] x_d [DEPTH];

        always_comb begin
            v_d = clr ? '0 : v_q;
            x_d = x_q;
            if (wr_en[g]) begin
                v_d[wr_row[g]] = 1'b1;
                x_d[wr_row[g]] = wr_x[g];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= '0;
            end else begin
                v_q <= v_d;
            end
        end

        always_ff @(posedge clk) begin
            x_q <= x_d;
        end

        assign rd_v[g] = v_q[rd_row];
        assign rd_x[g] = x_q[rd_row];
    end
endmodule

// File: rtl/tri_span_raster.sv
module tri_span_raster
    import tri_raster_pkg::*;
#(
    parameter int CRD_W = 8,
    parameter int COL_W = 8,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CRD_W-1:0] v1_x,
    input  logic [CRD_W-1:0] v1_y,
    input  logic [CRD_W-1:0] v2_x,
    input  logic [CRD_W-1:0] v2_y,
    input  logic [CRD_W-1:0] v3_x,
    input  logic [CRD_W-1:0] v3_y,
    input  logic [COL_W-1:0] fill_col,
    output logic             busy,
    output logic             done,
    output logic             pix_valid,
    input  logic             pix_ready,
    output logic [CRD_W-1:0] pix_x,
    output logic [CRD_W-1:0] pix_y,
    output logic [COL_W-1:0] pix_col
);
    localparam int RW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        span_st_e         st;
        logic [RW-1:0]    row;
        logic [RW-1:0]    nrows;
        logic [CRD_W-1:0] ymin;
        logic [CRD_W-1:0] cur_x;
        logic [CRD_W-1:0] stop_x;
        logic [COL_W-1:0] col;
    } ctl_t;

    ctl_t q, d;

    logic                        accept;
    logic [CRD_W-1:0]            ymin_c, ymax_c;
    logic [NSLOT-1:0][CRD_W-1:0] ax, ay, bx, by;
    logic [NSLOT-1:0]            wr_en, fin, rd_v;
    logic [NSLOT-1:0][RW-1:0]    wr_row;
    logic [NSLOT-1:0][CRD_W-1:0] wr_x, rd_x;
    logic [CRD_W-1:0]            lo, hi;
    logic                        any_v;

    assign ax[0] = v1_x;  assign ay[0] = v1_y;  assign bx[0] = v2_x;  assign by[0] = v2_y;
    assign ax[1] = v2_x;  assign ay[1] = v2_y;  assign bx[1] = v3_x;  assign by[1] = v3_y;
    assign ax[2] = v3_x;  assign ay[2] = v3_y;  assign bx[2] = v1_x;  assign by[2] = v1_y;

    assign accept = start && (q.st == SP_IDLE);

    for (genvar g = 0; g < NSLOT; g++) begin : g_edge
        tri_edge_walker #(.CRD_W(CRD_W), .RW(RW)) u_walk (
            .clk      (clk),
            .rst_n    (rst_n),
            .go       (accept),
            .ax       (ax[g]),
            .ay       (ay[g]),
            .bx       (bx[g]),
            .by       (by[g]),
            .y_base   (ymin_c),
            .wr_en    (wr_en[g]),
            .wr_row   (wr_row[g]),
            .wr_x     (wr_x[g]),
            .finished (fin[g])
        );
    end

    tri_span_table #(.CRD_W(CRD_W), .DEPTH(DEPTH), .RW(RW)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept),
        .wr_en  (wr_en),
        .wr_row (wr_row),
        .wr_x   (wr_x),
        .rd_row (q.row),
        .rd_v   (rd_v),
        .rd_x   (rd_x)
    );

    // vertex extent and per-row run limits
    always_comb begin
        ymin_c = v1_y;
        ymax_c = v1_y;
        if (v2_y < ymin_c) ymin_c = v2_y;
        if (v3_y < ymin_c) ymin_c = v3_y;
        if (v2_y > ymax_c) ymax_c = v2_y;
        if (v3_y > ymax_c) ymax_c = v3_y;
        lo    = '1;
        hi    = '0;
        any_v = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            if (rd_v[s]) begin
                any_v = 1'b1;
                if (rd_x[s] < lo) lo = rd_x[s];
                if (rd_x[s] > hi) hi = rd_x[s];
            end
        end
    end

    always_comb begin
        d = q;
        case (q.st)
            SP_IDLE: begin
                if (start) begin
                    d.st    = SP_WALK;
                    d.ymin  = ymin_c;
                    d.nrows = RW'(ymax_c - ymin_c);
                    d.col   = fill_col;
                    d.row   = '0;
                end
            end
            SP_WALK: begin
                if (&fin) d.st = SP_SCAN;
            end
            SP_SCAN: begin
                if (any_v) begin
                    d.cur_x  = lo;
                    d.stop_x = hi;
                    d.st     = SP_EMIT;
                end else if (q.row == q.nrows) begin
                    d.st = SP_DONE;
                end else begin
                    d.row = q.row + 1'b1;
                end
            end
            SP_EMIT: begin
                if (pix_ready) begin
                    if (q.cur_x != q.stop_x) begin
                        d.cur_x = q.cur_x + 1'b1;
                    end else if (q.row == q.nrows) begin
                        d.st = SP_DONE;
                    end else begin
                        d.row = q.row + 1'b1;
                        d.st  = SP_SCAN;
                    end
                end
            end
            SP_DONE: d.st = SP_IDLE;
            default: d.st = SP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != SP_IDLE);
    assign done      = (q.st == SP_DONE);
    assign pix_valid = (q.st == SP_EMIT);
    assign pix_x     = q.cur_x;
    assign pix_y     = q.ymin + CRD_W'(q.row);
    assign pix_col   = q.col;
endmodule

// File: rtl/tri_span_raster_chk.sv
module tri_span_raster_chk #(
    parameter int CRD_W = 8,
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] fill_col,
    input logic             busy,
    input logic             done,
    input logic             pix_valid,
    input logic             pix_ready,
    input logic [CRD_W-1:0] pix_x,
    input logic [CRD_W-1:0] pix_y,
    input logic [COL_W-1:0] pix_col
);
    logic [COL_W-1:0] col_q;
    logic [CRD_W-1:0] prev_x, prev_y;
    logic             have_prev;
    logic             acc;

    assign acc = pix_valid && pix_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q     <= '0;
            prev_x    <= '0;
            prev_y    <= '0;
            have_prev <= 1'b0;
        end else begin
            if (start && !busy) begin
                col_q     <= fill_col;
                have_prev <= 1'b0;
            end else if (acc) begin
                prev_x    <= pix_x;
                prev_y    <= pix_y;
                have_prev <= 1'b1;
            end
        end
    end

    p_valid_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> busy);

    p_rows_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && have_prev && pix_y != prev_y) |-> (pix_y > prev_y));

    p_left_to_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && have_prev && pix_y == prev_y) |-> (pix_x == prev_x + 1'b1));

    p_flat_colour_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_col == col_q));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_x) && $stable(pix_y) && $stable(pix_col)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

bind tri_span_raster tri_span_raster_chk #(.CRD_W(CRD_W), .COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .fill_col  (fill_col),
    .busy      (busy),
    .done      (done),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .pix_col   (pix_col)
);

// File: tb/test_tri_span_raster.sv
`timescale 1ns/1ps
module test_tri_span_raster;
    localparam int CW    = 8;
    localparam int COLW  = 8;
    localparam int DEPTH = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n, start, busy, done, pix_valid, pix_ready;
    logic [CW-1:0]   v1_x, v1_y, v2_x, v2_y, v3_x, v3_y, pix_x, pix_y;
    logic [COLW-1:0] fill_col, pix_col;

    int checks = 0;
    int fails  = 0;
    int exp_x[$];
    int exp_y[$];

    tri_span_raster #(.CRD_W(CW), .COL_W(COLW), .DEPTH(DEPTH)) i_tri_span_raster (
        .clk(clk), .rst_n(rst_n), .start(start),
        .v1_x(v1_x), .v1_y(v1_y), .v2_x(v2_x), .v2_y(v2_y), .v3_x(v3_x), .v3_y(v3_y),
        .fill_col(fill_col), .busy(busy), .done(done),
        .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_x(pix_x), .pix_y(pix_y), .pix_col(pix_col)
    );

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, expv);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // model of edge tracing and per-row min/max (R4, R5)
    task automatic build_exp(input int ax, input int ay, input int bx, input int by,
                             input int cx, input int cy);
        int px[3];
        int py[3];
        int tx[3][DEPTH];
        bit tv[3][DEPTH];
        int ymin, ymax, x, y, xe, ye, dx, ndy, sx, sy, err, e2, lo, hi;
        px = '{ax, bx, cx};
        py = '{ay, by, cy};
        ymin = ay; ymax = ay;
        if (by < ymin) ymin = by;
        if (cy < ymin) ymin = cy;
        if (by > ymax) ymax = by;
        if (cy > ymax) ymax = cy;
        for (int s = 0; s < 3; s++)
            for (int r = 0; r < DEPTH; r++) tv[s][r] = 1'b0;
        for (int s = 0; s < 3; s++) begin
            x = px[s]; y = py[s];
            xe = px[(s + 1) % 3]; ye = py[(s + 1) % 3];
            dx = iabs(xe - x); ndy = -iabs(ye - y);
            sx = (xe < x) ? -1 : 1; sy = (ye < y) ? -1 : 1;
            err = dx + ndy;
            forever begin
                tx[s][y - ymin] = x;
                tv[s][y - ymin] = 1'b1;
                if (x == xe && y == ye) break;
                e2 = 2 * err;
                if (e2 >= ndy) begin err += ndy; x += sx; end
                if (e2 <= dx)  begin err += dx;  y += sy; end
            end
        end
        exp_x.delete();
        exp_y.delete();
        for (int r = 0; r <= ymax - ymin; r++) begin
            lo = 1 << 30; hi = -1;
            for (int s = 0; s < 3; s++) begin
                if (tv[s][r]) begin
                    if (tx[s][r] < lo) lo = tx[s][r];
                    if (tx[s][r] > hi) hi = tx[s][r];
                end
            end
            for (int xx = lo; xx <= hi; xx++) begin
                exp_x.push_back(xx);
                exp_y.push_back(r + ymin);
            end
        end
    endtask

    // rmode: 0 ready always high, 1 alternating, 2 pseudo-random
    task automatic t_draw(input string tag, input int ax, input int ay, input int bx, input int by,
                          input int cx, input int cy, input int col, input int rmode, input bit poke);
        int got_x[$];
        int got_y[$];
        int cyc, first_acc, done_cyc, bad_idx, col_err, stall_err;
        bit stall_prev;
        int sx_prev, sy_prev;
        logic [7:0] lfsr;
        build_exp(ax, ay, bx, by, cx, cy);
        @(negedge clk);
        v1_x = CW'(ax); v1_y = CW'(ay); v2_x = CW'(bx); v2_y = CW'(by);
        v3_x = CW'(cx); v3_y = CW'(cy); fill_col = COLW'(col);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {"R2 busy after start ", tag}, int'(busy), 1);
        cyc = 0; first_acc = -1; done_cyc = -1; col_err = 0; stall_err = 0;
        stall_prev = 1'b0; sx_prev = 0; sy_prev = 0; lfsr = 8'hA5;
        forever begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (rmode)
                0: pix_ready = 1'b1;
                1: pix_ready = cyc[0];
                default: pix_ready = lfsr[0];
            endcase
            if (poke && cyc == 3) begin
                start = 1'b1;
                v1_x = 8'd0; v1_y = 8'd0; v2_x = 8'd255; v2_y = 8'd20; v3_x = 8'd3; v3_y = 8'd9;
                fill_col = ~COLW'(col);
            end else begin
                start = 1'b0;
            end
            if (stall_prev && !(pix_valid && int'(pix_x) == sx_prev && int'(pix_y) == sy_prev))
                stall_err++;
            if (pix_valid && pix_ready) begin
                got_x.push_back(int'(pix_x));
                got_y.push_back(int'(pix_y));
                if (int'(pix_col) != col) col_err++;
                if (first_acc < 0) first_acc = cyc;
            end
            stall_prev = pix_valid && !pix_ready;
            sx_prev = int'(pix_x);
            sy_prev = int'(pix_y);
            if (done) begin
                done_cyc = cyc;
                break;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(got_x.size() == exp_x.size(), {"R3 pixel count ", tag}, got_x.size(), exp_x.size());
        bad_idx = -1;
        for (int i = 0; i < got_x.size() && i < exp_x.size(); i++)
            if (bad_idx < 0 && (got_x[i] != exp_x[i] || got_y[i] != exp_y[i])) bad_idx = i;
        if (bad_idx >= 0)
            chk(1'b0, {"R4 R5 pixel x at first mismatch ", tag}, got_x[bad_idx], exp_x[bad_idx]);
        else
            chk(1'b1, {"R4 R5 pixel order ", tag}, 0, 0);
        chk(col_err == 0, {"R6 colour mismatches ", tag}, col_err, 0);
        chk(stall_err == 0, {"R7 stall hold violations ", tag}, stall_err, 0);
        if (rmode == 0)
            chk(done_cyc - first_acc <= 3 * exp_x.size(), {"R10 emit cycles ", tag},
                done_cyc - first_acc, 3 * exp_x.size());
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, {"R8 done one cycle then idle ", tag},
            int'({done, busy}), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start = 1'b0; pix_ready = 1'b0;
        v1_x = '0; v1_y = '0; v2_x = '0; v2_y = '0; v3_x = '0; v3_y = '0; fill_col = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pix_valid, "R1 outputs in reset", int'({busy, done, pix_valid}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !pix_valid, "R1 outputs after reset", int'({busy, done, pix_valid}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_draw("basic", 20, 2, 60, 14, 8, 25, 8'h5A, 0, 1'b0);
        t_draw("shallow R4", 2, 5, 200, 9, 120, 20, 8'h33, 1, 1'b0);
        t_draw("reverse winding R5", 8, 25, 60, 14, 20, 2, 8'hC3, 2, 1'b0);
        t_draw("point R11", 30, 30, 30, 30, 30, 30, 8'h11, 0, 1'b0);
        t_draw("flat row R11", 5, 40, 90, 40, 40, 40, 8'h22, 2, 1'b0);
        t_draw("sliver", 100, 3, 101, 28, 100, 28, 8'h44, 0, 1'b0);
        t_draw("tall before R9", 10, 0, 200, 15, 10, 30, 8'h66, 0, 1'b0);
        t_draw("short after R9", 50, 0, 60, 5, 50, 10, 8'h77, 0, 1'b0);
        t_draw("start while busy R2", 20, 2, 60, 14, 8, 25, 8'h99, 0, 1'b1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule